// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART's serial shifters and an infrared transceiver. It converts the UART bit stream into the pulse form used by slow infrared links, and converts it back. On the transmit side, every zero bit becomes one short light pulse at the start of the bit, and a one bit sends nothing. The pulse is either three sixteenths of a bit period long, counted on the UART's 16x baud tick, or a fixed 1.6 us counted in system clocks. On the receive side, each detected pulse is stretched back into a zero bit of full width.

Each direction has its own enable. When an enable is off, that path passes the plain UART signal through unchanged. Transmit pulse polarity and expected receive pulse polarity are set separately, so the block can drive and read transceivers with either active level. Every control input is a static level that the surrounding logic sets while the link is idle.

Top module: `irda_sir_codec`

## Requirements
- R1: With `tx_sir_en` low, `ir_txd` equals `uart_txd` combinationally in every cycle.
- R2: With `rx_sir_en` low, `uart_rxd` equals `ir_rxd` combinationally in every cycle.
- R3: With `tx_sir_en` high and `uart_txd` high with no pulse in progress, `ir_txd` stays at the idle level. The idle level is 0 when `tx_pulse_low` is 0 and 1 when it is 1.
- R4: In tick mode (`tx_fixed_pulse` = 0), a falling edge of `uart_txd` starts a pulse on `ir_txd` one clock later. The pulse ends at the third `baud_tick` after it starts. While `uart_txd` stays low, a new pulse starts every 16 ticks, at the tick that completes each bit.
- R5: In fixed mode (`tx_fixed_pulse` = 1), each pulse lasts exactly `FIX_CYCLES` clocks. `FIX_CYCLES` is `CLK_HZ` times 1.6 us, which is 80 at the default 50 MHz.
- R6: With `tx_pulse_low` = 1, the pulse level on `ir_txd` is 0 and the idle level is 1. With `tx_pulse_low` = 0, the pulse level is 1 and the idle level is 0.
- R7: With `rx_sir_en` high, a transition of `ir_rxd` into its pulse level drives `uart_rxd` low at the third clock edge after the transition. This delay consists of two synchronizer stages and one hold register. `uart_rxd` then stays low until the 16th `baud_tick` after that edge.
- R8: With `rx_pulse_low` = 0, the pulse level on `ir_rxd` is 1. With `rx_pulse_low` = 1, the pulse level is 0.
- R9: A new receive pulse that arrives while `uart_rxd` is being held low restarts the 16-tick hold.
- R10: While `rst_n` is low at a clock edge, with both enables high and no pulse present, `ir_txd` is at the idle level and `uart_rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-clock strobe at 16 times the bit rate |
| uart_txd | input | 1 | Serial bit stream from the UART transmitter |
| ir_rxd | input | 1 | Signal from the infrared receiver |
| tx_sir_en | input | 1 | 1: encode transmit pulses; 0: pass `uart_txd` through |
| rx_sir_en | input | 1 | 1: decode receive pulses; 0: pass `ir_rxd` through |
| tx_fixed_pulse | input | 1 | 0: pulse is 3 baud ticks; 1: pulse is a fixed 1.6 us |
| tx_pulse_low | input | 1 | 1: transmit pulses are low-going |
| rx_pulse_low | input | 1 | 1: receive pulses are expected low-going |
| ir_txd | output | 1 | Drive to the infrared transmitter |
| uart_rxd | output | 1 | Rebuilt serial stream to the UART receiver |

## Verification
A wrong bit-phase count in the encoder makes the repeated pulses of a run of zeros land off the 16-tick grid. This shows on `ir_txd` within one bit time. A wrong pulse-length counter changes the pulse width, which is visible as soon as the first pulse ends. In the decoder, a fault in the synchronizer or the edge detector moves or drops the falling edge of `uart_rxd` within three clocks. A fault in the hold counter changes the width of the rebuilt zero, which is visible when that bit ends. The bench compares both outputs against a reference model on every clock, so any such fault is reported in the cycle where it first appears.

// File: rtl/sir_pkg.sv
// Shared helpers for the infrared SIR codec.
// Assumes the clock frequency is a whole number of kHz.
package sir_pkg;

    // Number of system clocks in a pulse of the given length in nanoseconds, at least one.
    function automatic int unsigned pulse_cycles(input int unsigned clk_hz,
                                                 input int unsigned pulse_ns);
        int unsigned n;
        n = ((clk_hz / 1000) * pulse_ns) / 1_000_000;
        return (n == 0) ? 1 : n;
    endfunction

    // Larger of two counts, used to size counters.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sir_sync.sv
// Multi-stage synchronizer for one asynchronous input bit.
// Assumes the input stays at a level for well over STAGES clocks.
module sir_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage: captures the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Later stages: let a metastable value settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sir_tx_encoder.sv
// Transmit encoder: turns each zero bit of the UART stream into a short pulse.
// A falling edge of uart_txd realigns the bit phase. A run of zeros gets one
// pulse per bit, at the tick that completes each 16-tick bit.
// Pulse length is PULSE_TICKS baud ticks, or FIX_CYCLES clocks in fixed mode.
// Assumes the mode and polarity inputs only change while no pulse is in progress.
module sir_tx_encoder #(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned PULSE_TICKS   = 3,
    parameter int unsigned FIX_CYCLES    = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic uart_txd,
    input  logic sir_en,
    input  logic fixed_pulse,
    input  logic pulse_low,
    output logic ir_txd
);
    import sir_pkg::*;

    localparam int unsigned PH_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int unsigned CNT_W = $clog2(max_u(FIX_CYCLES, PULSE_TICKS) + 1);
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] LOAD_TICK = CNT_W'(PULSE_TICKS);
    localparam logic [CNT_W-1:0] LOAD_FIX  = CNT_W'(FIX_CYCLES);

    logic             txd_q;
    logic [PH_W-1:0]  bit_ph;
    logic [CNT_W-1:0] pulse_cnt;
    logic             txd_fall;
    logic             bit_wrap;
    logic             pulse_start;
    logic             pulse_act;

    // Decide when a pulse begins: a new zero after a one, or another zero bit in a run.
    always_comb begin
        txd_fall    = txd_q & ~uart_txd;
        bit_wrap    = baud_tick & ~uart_txd & (bit_ph == PH_LAST);
        pulse_start = txd_fall | bit_wrap;
    end

    // Remember the last transmit bit for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= uart_txd;
    end

    // Count ticks within the current bit; realign at each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                bit_ph <= '0;
        else if (txd_fall)         bit_ph <= '0;
        else if (baud_tick)        bit_ph <= (bit_ph == PH_LAST) ? '0 : bit_ph + PH_W'(1);
    end

    // Pulse length counter: loaded at start, counts ticks or clocks by mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_cnt <= '0;
        else if (pulse_start)
            pulse_cnt <= fixed_pulse ? LOAD_FIX : LOAD_TICK;
        else if (pulse_cnt != '0 && (fixed_pulse || baud_tick))
            pulse_cnt <= pulse_cnt - CNT_W'(1);
    end

    assign pulse_act = (pulse_cnt != '0);

    // Output select: encoded pulses with polarity, or plain pass-through.
    always_comb begin
        if (sir_en) ir_txd = pulse_act ^ pulse_low;
        else        ir_txd = uart_txd;
    end

    // R4: a falling transmit bit starts a pulse on the next clock.
    assert_zero_bit_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uart_txd) |=> pulse_act);

    // R3: a one bit with no pulse running keeps the line dark.
    assert_one_bit_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_act && uart_txd) |=> !pulse_act);

    // R4: in tick mode a pulse only ends on a baud tick.
    assert_tick_pulse_ends_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_act) && !$past(fixed_pulse)) |-> $past(baud_tick));

    // R5: in fixed mode a running pulse is not cut short by a baud tick.
    assert_fixed_pulse_ignores_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_pulse && pulse_cnt > CNT_W'(1) && !uart_txd) |=> pulse_act);
endmodule

// File: rtl/sir_rx_decoder.sv
// Receive decoder: rebuilds full-width zero bits from infrared pulses.
// The input is synchronized, polarity-corrected and edge-detected. Each pulse
// edge holds the output low for TICKS_PER_BIT baud ticks, and a later pulse
// restarts the hold.
// Assumes pulses are at least SYNC_STAGES clocks wide.
module sir_rx_decoder #(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic ir_rxd,
    input  logic sir_en,
    input  logic pulse_low,
    output logic uart_rxd
);
    localparam int unsigned HOLD_W = $clog2(TICKS_PER_BIT + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(TICKS_PER_BIT);

    logic              ir_sync;
    logic              pulse_lvl;
    logic              lvl_q;
    logic              rx_start;
    logic [HOLD_W-1:0] hold_cnt;
    logic              rx_bit;

    sir_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ir_rxd),
        .q     (ir_sync)
    );

    // Map the synchronized input to "pulse present" and find its leading edge.
    always_comb begin
        pulse_lvl = ir_sync ^ pulse_low;
        rx_start  = pulse_lvl & ~lvl_q;
    end

    // Previous pulse level; resets as present so reset release makes no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= pulse_lvl;
    end

    // Hold counter: reloaded on each pulse edge, counts down on baud ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hold_cnt <= '0;
        else if (rx_start)                  hold_cnt <= HOLD_LOAD;
        else if (baud_tick && hold_cnt != '0) hold_cnt <= hold_cnt - HOLD_W'(1);
    end

    assign rx_bit = (hold_cnt == '0);

    // Output select: rebuilt bit, or plain pass-through.
    always_comb begin
        if (sir_en) uart_rxd = rx_bit;
        else        uart_rxd = ir_rxd;
    end

    // R7: a detected pulse edge drives the rebuilt bit low on the next clock.
    assert_pulse_forces_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !rx_bit);

    // R7: the rebuilt zero only ends on a baud tick.
    assert_hold_ends_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_bit) |-> $past(baud_tick));

    // R9: the hold never grows except when a new pulse reloads it.
    assert_hold_only_reloads_on_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_start |=> hold_cnt <= $past(hold_cnt));
endmodule

// File: rtl/irda_sir_codec.sv
// Infrared SIR pulse codec top level.
// Joins the transmit encoder and the receive decoder; the two paths share only
// the clock, the reset and the baud tick.
// Assumes baud_tick is a one-clock strobe at 16 times the bit rate.
module irda_sir_codec #(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned PULSE_NS      = 1600,
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned PULSE_TICKS   = 3,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic uart_txd,
    input  logic ir_rxd,
    input  logic tx_sir_en,
    input  logic rx_sir_en,
    input  logic tx_fixed_pulse,
    input  logic tx_pulse_low,
    input  logic rx_pulse_low,
    output logic ir_txd,
    output logic uart_rxd
);
    localparam int unsigned FIX_CYCLES = sir_pkg::pulse_cycles(CLK_HZ, PULSE_NS);

    sir_tx_encoder #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .PULSE_TICKS   (PULSE_TICKS),
        .FIX_CYCLES    (FIX_CYCLES)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .uart_txd    (uart_txd),
        .sir_en      (tx_sir_en),
        .fixed_pulse (tx_fixed_pulse),
        .pulse_low   (tx_pulse_low),
        .ir_txd      (ir_txd)
    );

    sir_rx_decoder #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .ir_rxd    (ir_rxd),
        .sir_en    (rx_sir_en),
        .pulse_low (rx_pulse_low),
        .uart_rxd  (uart_rxd)
    );

    // R1: with the transmit path disabled, a steady input gives a steady output.
    assert_tx_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_sir_en && $stable(uart_txd)) |-> (ir_txd == uart_txd));
endmodule

// File: tb/tb_irda_sir_codec.sv
module tb_irda_sir_codec;
    localparam int FIX      = 80;
    localparam int TICK_DIV = 27;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic uart_txd = 1'b1;
    logic ir_rxd = 1'b0;
    logic tx_sir_en = 1'b1;
    logic rx_sir_en = 1'b1;
    logic tx_fixed_pulse = 1'b0;
    logic tx_pulse_low = 1'b0;
    logic rx_pulse_low = 1'b0;
    wire  ir_txd;
    wire  uart_rxd;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";
    bit done = 0;

    irda_sir_codec dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .uart_txd(uart_txd),
        .ir_rxd(ir_rxd), .tx_sir_en(tx_sir_en), .rx_sir_en(rx_sir_en),
        .tx_fixed_pulse(tx_fixed_pulse), .tx_pulse_low(tx_pulse_low),
        .rx_pulse_low(rx_pulse_low), .ir_txd(ir_txd), .uart_rxd(uart_rxd)
    );

    always #10 clk = ~clk;

    // Baud tick strobe, one clock in every TICK_DIV.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        baud_tick = (tdiv == 0);
    end

    // Reference model state.
    bit m_prev_txd = 1;
    int m_phase = 0;
    int m_tick_left = 0;
    int m_cyc_left = 0;
    bit m_sync[2] = '{0, 0};
    bit m_lvl_prev = 1;
    int m_hold = 0;
    int tx_run = 0, tx_last = 0, rx_run = 0, rx_last = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance the model at each edge, then compare both outputs mid-cycle.
    always begin
        @(posedge clk);
        if (!rst_n) begin
            m_prev_txd = 1; m_phase = 0; m_tick_left = 0; m_cyc_left = 0;
            m_sync[0] = 0; m_sync[1] = 0; m_lvl_prev = 1; m_hold = 0;
        end else begin
            bit fall, wrap, start, lvl, rstart;
            fall  = m_prev_txd && !uart_txd;
            wrap  = baud_tick && !uart_txd && (m_phase == 15);
            start = fall || wrap;
            if (fall) m_phase = 0;
            else if (baud_tick) m_phase = (m_phase + 1) % 16;
            if (start) begin
                m_tick_left = 3; m_cyc_left = FIX;
            end else begin
                if (baud_tick && m_tick_left > 0) m_tick_left--;
                if (m_cyc_left > 0) m_cyc_left--;
            end
            m_prev_txd = uart_txd;
            lvl    = m_sync[1] ^ rx_pulse_low;
            rstart = lvl && !m_lvl_prev;
            if (rstart) m_hold = 16;
            else if (baud_tick && m_hold > 0) m_hold--;
            m_lvl_prev = lvl;
            m_sync[1] = m_sync[0];
            m_sync[0] = ir_rxd;
        end
        #5;
        begin
            bit act, exp_tx, exp_rx;
            act    = tx_fixed_pulse ? (m_cyc_left > 0) : (m_tick_left > 0);
            exp_tx = tx_sir_en ? (act ^ tx_pulse_low) : uart_txd;
            exp_rx = rx_sir_en ? (m_hold == 0) : ir_rxd;
            check(ir_txd === exp_tx, cur_req, "ir_txd", int'(ir_txd), int'(exp_tx));
            check(uart_rxd === exp_rx, cur_req, "uart_rxd", int'(uart_rxd), int'(exp_rx));
        end
        if (ir_txd !== tx_pulse_low) tx_run++;
        else if (tx_run > 0) begin tx_last = tx_run; tx_run = 0; end
        if (uart_rxd === 1'b0) rx_run++;
        else if (rx_run > 0) begin rx_last = rx_run; rx_run = 0; end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        uart_txd = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            uart_txd = b[i];
            wait_clks(BIT_CLKS);
        end
        uart_txd = 1'b1;
        wait_clks(2 * BIT_CLKS);
    endtask

    task automatic ir_pulse(input int width, input logic active);
        ir_rxd = active;
        wait_clks(width);
        ir_rxd = ~active;
    endtask

    initial begin
        // R10: reset state with both paths in IrDA mode.
        cur_req = "R10";
        wait_clks(5);
        check(ir_txd === 1'b0, "R10", "ir_txd in reset", int'(ir_txd), 0);
        check(uart_rxd === 1'b1, "R10", "uart_rxd in reset", int'(uart_rxd), 1);
        rst_n = 1'b1;
        wait_clks(50);

        // R4: tick-mode pulses, including a run of zero bits.
        cur_req = "R4";
        send_byte(8'hA5);
        check(tx_last >= 2 * TICK_DIV + 1 && tx_last <= 3 * TICK_DIV, "R4",
              "tick pulse width", tx_last, 3 * TICK_DIV);
        send_byte(8'h00);
        check(tx_last >= 2 * TICK_DIV + 1 && tx_last <= 3 * TICK_DIV, "R4",
              "run pulse width", tx_last, 3 * TICK_DIV);

        // R5: fixed-length pulses.
        cur_req = "R5";
        tx_fixed_pulse = 1'b1;
        send_byte(8'h3C);
        check(tx_last == FIX, "R5", "fixed pulse width", tx_last, FIX);

        // R6: low-going transmit pulses.
        cur_req = "R6";
        tx_pulse_low = 1'b1;
        wait_clks(10);
        check(ir_txd === 1'b1, "R6", "inverted idle level", int'(ir_txd), 1);
        send_byte(8'h5A);
        check(tx_last == FIX, "R6", "inverted pulse width", tx_last, FIX);

        // R3: an all-ones byte only pulses for its start bit.
        cur_req = "R3";
        tx_pulse_low = 1'b0;
        tx_fixed_pulse = 1'b0;
        wait_clks(BIT_CLKS + 5);
        tx_run = 0;
        send_byte(8'hFF);
        check(ir_txd === 1'b0, "R3", "idle after ones", int'(ir_txd), 0);

        // R1: transmit pass-through.
        cur_req = "R1";
        tx_sir_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            uart_txd = i[0];
            wait_clks(7);
            check(ir_txd === uart_txd, "R1", "pass-through", int'(ir_txd), int'(uart_txd));
        end
        uart_txd = 1'b1;
        tx_sir_en = 1'b1;
        wait_clks(BIT_CLKS);

        // R7: one positive pulse rebuilds one zero bit.
        cur_req = "R7";
        ir_pulse(3 * TICK_DIV, 1'b1);
        wait_clks(BIT_CLKS + 60);
        check(rx_last >= 15 * TICK_DIV + 1 && rx_last <= 16 * TICK_DIV, "R7",
              "rebuilt zero width", rx_last, 16 * TICK_DIV);

        // R9: a second pulse during the hold restarts it.
        cur_req = "R9";
        ir_pulse(3 * TICK_DIV, 1'b1);
        wait_clks(3 * TICK_DIV);
        ir_pulse(3 * TICK_DIV, 1'b1);
        wait_clks(BIT_CLKS + 60);
        check(rx_last > 21 * TICK_DIV, "R9", "restarted hold width", rx_last, 22 * TICK_DIV);

        // R8: low-going receive pulses.
        cur_req = "R8";
        rx_pulse_low = 1'b1;
        ir_rxd = 1'b1;
        wait_clks(BIT_CLKS + 60);
        ir_pulse(3 * TICK_DIV, 1'b0);
        wait_clks(BIT_CLKS + 60);
        check(rx_last >= 15 * TICK_DIV + 1 && rx_last <= 16 * TICK_DIV, "R8",
              "inverted rebuilt zero", rx_last, 16 * TICK_DIV);

        // R2: receive pass-through.
        cur_req = "R2";
        rx_sir_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            ir_rxd = i[0];
            wait_clks(5);
            check(uart_rxd === ir_rxd, "R2", "pass-through", int'(uart_rxd), int'(ir_rxd));
        end
        wait_clks(20);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule